// File: doc/BRIEF.md
# ADC Result Threshold Comparator

This block watches the stream of finished conversion results coming out of an analog-to-digital converter and raises an alarm when one chosen channel keeps producing results on one side of a programmed threshold. Two comparators run side by side on the same stream, and each is set up on its own. A comparator is configured with a single write that carries an enable bit, a condition select, a run length, a source channel and a threshold. It counts consecutive results from its source channel that meet the condition. When that run reaches the programmed length, it sets a sticky match flag.

The flag stays set until software writes 1 to the matching clear bit. The run counter starts again from zero every time the flag fires, so another full run is needed before the next alarm. A result from the source channel that fails the condition breaks the run. Results from any other channel leave the run as it is. Any configuration write starts the run over.

Results arrive on a valid/ready port. The block takes a result on every cycle in which `res_valid` is high. It never applies back-pressure: `res_ready` is held high, so a producer may treat each valid cycle as an accepted transfer. Configuration and flag clearing use plain per-comparator write strobes.

Top module: `adc_thresh_cmp`

## Requirements
- R1: After reset both match flags are 0, and `res_ready` is 1 in every cycle, so every cycle with `res_valid` high is an accepted result.
- R2: Configuration word layout: bit 0 is the enable, bit 1 is the condition, bits 5:2 hold the run length minus one, bits 8:6 hold the source channel (0 to 7), and bits 20:9 hold the 12-bit threshold.
- R3: Condition 0 qualifies a result strictly below the threshold. Condition 1 qualifies a result equal to or above the threshold.
- R4: The flag sets on the edge that accepts the N-th consecutive qualifying result from the source channel, where N is the stored field plus one (1 to 16). A flag never rises on an edge with no accepted result.
- R5: A result from the source channel that does not qualify resets the run to zero.
- R6: Results whose 4-bit channel index differs from the source channel leave the run unchanged. This includes indexes 8 to 15, whose low three bits equal the source.
- R7: The flag is sticky. A 1 on `flag_clr[k]` clears flag k. If the flag sets in the same cycle as a clear, the set wins.
- R8: When the flag sets, the run restarts from zero, so N further qualifying results are needed to set it again.
- R9: A configuration write clears the run and leaves the flag unchanged. A result accepted in the same cycle as the write is ignored by that comparator.
- R10: With the enable bit 0, the comparator neither counts nor sets its flag.
- R11: The two comparators are independent: the configuration, run and flag of one are not affected by writes, clears or matches of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A conversion result is offered |
| res_ready | output | 1 | Result accepted; always 1 |
| res_chan | input | 4 | Channel index of the offered result |
| res_data | input | 12 | Conversion result value |
| cfg_we | input | 2 | Per-comparator configuration write strobe |
| cfg_wdata | input | 21 | Configuration word (layout in R2) |
| flag_clr | input | 2 | Per-comparator write-1-to-clear of the match flag |
| match_flag | output | 2 | Sticky match flag per comparator |

## Verification
The bench checks that a result exactly equal to the threshold counts for the at-or-above condition and breaks the run for the below condition. A design that gets this wrong fires one result early or late. It sends channel 13 while the source is 5. A design that compares only the low channel bits would count that result and fire early. It overlaps a set with a clear, and a result with a configuration write. The bench also runs the 16-long run at the top of the length field. A wrong design there would lose an alarm, count a stale result, or overflow its counter. A reference model computes the expected flags on every clock, and directed checks pin the exact cycle of each flag change.

// File: rtl/adcthr_pkg.sv
package adcthr_pkg;
  typedef enum logic {
    COND_BELOW       = 1'b0,
    COND_AT_OR_ABOVE = 1'b1
  } cond_e;

  // Width of one configuration word: enable, condition, run length, source, threshold
  function automatic int cfg_width(int cnt_w, int src_w, int data_w);
    return 2 + cnt_w + src_w + data_w;
  endfunction
endpackage

// File: rtl/adcthr_qualify.sv
module adcthr_qualify
  import adcthr_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int SRC_W  = 3,
  parameter int DATA_W = 12
) (
  input  logic              enable,
  input  logic              valid,
  input  logic [CHAN_W-1:0] chan,
  input  logic [SRC_W-1:0]  source,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] threshold,
  input  cond_e             cond,
  output logic              selected,
  output logic              hit
);
  // Full-width channel compare: indexes above the source range never alias
  assign selected = enable && valid && (chan == CHAN_W'(source));

  always_comb begin
    case (cond)
      COND_BELOW: hit = (sample < threshold);
      default:    hit = (sample >= threshold);
    endcase
  end
endmodule

// File: rtl/adcthr_unit.sv
module adcthr_unit
  import adcthr_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int SRC_W  = 3,
  parameter int DATA_W = 12,
  parameter int CNT_W  = 4,
  localparam int CFG_W = cfg_width(CNT_W, SRC_W, DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              res_valid,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic              flag_clr,
  output logic              flag
);
  localparam int LEN_LO = 2;
  localparam int SRC_LO = LEN_LO + CNT_W;
  localparam int THR_LO = SRC_LO + SRC_W;

  logic              en_q;
  cond_e             cond_q;
  logic [CNT_W-1:0]  len_q;
  logic [SRC_W-1:0]  src_q;
  logic [DATA_W-1:0] thr_q;
  logic [CNT_W-1:0]  run_q;
  logic              selected, hit, run_done, fire;

  adcthr_qualify #(.CHAN_W(CHAN_W), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_qual (
    .enable   (en_q),
    .valid    (res_valid),
    .chan     (res_chan),
    .source   (src_q),
    .sample   (res_data),
    .threshold(thr_q),
    .cond     (cond_q),
    .selected (selected),
    .hit      (hit)
  );

  assign run_done = (run_q == len_q);
  assign fire     = !cfg_we && selected && hit && run_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cond_q <= COND_BELOW;
      len_q  <= '0;
      src_q  <= '0;
      thr_q  <= '0;
      run_q  <= '0;
    end else if (cfg_we) begin
      en_q   <= cfg_wdata[0];
      cond_q <= cond_e'(cfg_wdata[1]);
      len_q  <= cfg_wdata[SRC_LO-1:LEN_LO];
      src_q  <= cfg_wdata[THR_LO-1:SRC_LO];
      thr_q  <= cfg_wdata[CFG_W-1:THR_LO];
      run_q  <= '0;
    end else if (selected) begin
      if (!hit || run_done) run_q <= '0;
      else                  run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (fire)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/adc_thresh_cmp.sv
module adc_thresh_cmp
  import adcthr_pkg::*;
#(
  parameter int NCMP   = 2,
  parameter int CHAN_W = 4,
  parameter int SRC_W  = 3,
  parameter int DATA_W = 12,
  parameter int CNT_W  = 4,
  localparam int CFG_W = cfg_width(CNT_W, SRC_W, DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic [NCMP-1:0]   cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [NCMP-1:0]   flag_clr,
  output logic [NCMP-1:0]   match_flag
);
  // The comparators only observe the stream; they never stall it
  assign res_ready = 1'b1;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    adcthr_unit #(
      .CHAN_W(CHAN_W), .SRC_W(SRC_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we[g]),
      .cfg_wdata(cfg_wdata),
      .res_valid(res_valid),
      .res_chan (res_chan),
      .res_data (res_data),
      .flag_clr (flag_clr[g]),
      .flag     (match_flag[g])
    );
  end
endmodule

// File: rtl/adcthr_check.sv
module adcthr_check #(
  parameter int NCMP = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            res_valid,
  input logic            res_ready,
  input logic [NCMP-1:0] cfg_we,
  input logic [NCMP-1:0] flag_clr,
  input logic [NCMP-1:0] match_flag
);
  assert_ready_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready);

  for (genvar g = 0; g < NCMP; g++) begin : g_chk
    assert_rise_needs_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> !$rose(match_flag[g]));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      match_flag[g] && !flag_clr[g] |=> match_flag[g]);

    assert_clear_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr[g] && !res_valid |=> !match_flag[g]);

    assert_cfg_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we[g] && !match_flag[g] |=> !match_flag[g]);
  end
endmodule

bind adc_thresh_cmp adcthr_check #(.NCMP(NCMP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .cfg_we    (cfg_we),
  .flag_clr  (flag_clr),
  .match_flag(match_flag)
);

// File: tb/sim_adc_thresh_cmp.sv
`timescale 1ns/1ps
module sim_adc_thresh_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [3:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic [1:0]  cfg_we = '0;
  logic [20:0] cfg_wdata = '0;
  logic [1:0]  flag_clr = '0;
  logic [1:0]  match_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_thresh_cmp u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .flag_clr(flag_clr), .match_flag(match_flag)
  );

  // Behavioural reference model, updated on each rising edge
  int m_en[2], m_cond[2], m_len[2], m_src[2], m_thr[2], m_run[2], m_flag[2];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      bit set_now;
      set_now = 1'b0;
      if (!rst_n) begin
        m_en[k] = 0; m_cond[k] = 0; m_len[k] = 1; m_src[k] = 0;
        m_thr[k] = 0; m_run[k] = 0; m_flag[k] = 0;
      end else begin
        if (cfg_we[k]) begin
          m_en[k]   = int'(cfg_wdata[0]);
          m_cond[k] = int'(cfg_wdata[1]);
          m_len[k]  = int'(cfg_wdata[5:2]) + 1;
          m_src[k]  = int'(cfg_wdata[8:6]);
          m_thr[k]  = int'(cfg_wdata[20:9]);
          m_run[k]  = 0;
        end else if (m_en[k] != 0 && res_valid && int'(res_chan) == m_src[k]) begin
          bit ok;
          ok = (m_cond[k] != 0) ? (int'(res_data) >= m_thr[k]) : (int'(res_data) < m_thr[k]);
          if (ok) begin
            m_run[k] = m_run[k] + 1;
            if (m_run[k] == m_len[k]) begin
              m_run[k] = 0;
              set_now = 1'b1;
            end
          end else begin
            m_run[k] = 0;
          end
        end
        if (set_now)          m_flag[k] = 1;
        else if (flag_clr[k]) m_flag[k] = 0;
      end
    end
  end

  // Per-cycle comparison against the model (R3 R4 R5 R6 R11)
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        checks++;
        if (int'(match_flag[k]) != m_flag[k]) begin
          errors++;
          $display("FAIL R11 model cmp%0d t=%0t actual=%0d expected=%0d",
                   k, $time, match_flag[k], m_flag[k]);
        end
      end
    end
  end

  function automatic logic [20:0] mkcfg(bit en, bit cond, int n, int src, int thr);
    logic [20:0] w;
    w[0]     = en;
    w[1]     = cond;
    w[5:2]   = 4'(n - 1);
    w[8:6]   = 3'(src);
    w[20:9]  = 12'(thr);
    return w;
  endfunction

  // One cycle of stimulus; returns just after the edge that accepted it
  task automatic put(bit v, int ch, int d, logic [1:0] we, logic [20:0] wd, logic [1:0] clr);
    @(negedge clk);
    res_valid = v; res_chan = 4'(ch); res_data = 12'(d);
    cfg_we = we; cfg_wdata = wd; flag_clr = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic res(int ch, int d);
    put(1'b1, ch, d, 2'b00, '0, 2'b00);
  endtask

  task automatic idle();
    put(1'b0, 0, 0, 2'b00, '0, 2'b00);
  endtask

  task automatic expect_flag(int k, bit exp, string tag);
    checks++;
    if (match_flag[k] !== exp) begin
      errors++;
      $display("FAIL %s cmp%0d actual=%0b expected=%0b", tag, k, match_flag[k], exp);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    expect_flag(0, 1'b0, "R1 reset");
    expect_flag(1, 1'b0, "R1 reset");
    checks++;
    if (res_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 ready actual=%0b expected=1", res_ready);
    end

    // Comparator 0: at-or-above 0x800, run of 3 on channel 5
    put(1'b0, 0, 0, 2'b01, mkcfg(1, 1, 3, 5, 'h800), 2'b00);
    expect_flag(0, 1'b0, "R9 write keeps flag");
    res(5, 'h900);
    res(5, 'hFFF);
    expect_flag(0, 1'b0, "R4 run not reached");
    res(2, 'h100);
    expect_flag(0, 1'b0, "R6 other channel");
    res(13, 'h900);
    expect_flag(0, 1'b0, "R6 channel 13 aliasing");
    res(5, 'h800);
    expect_flag(0, 1'b1, "R3 R4 equal counts at-or-above");
    idle(); idle(); idle();
    expect_flag(0, 1'b1, "R7 sticky");
    put(1'b0, 0, 0, 2'b00, '0, 2'b01);
    expect_flag(0, 1'b0, "R7 clear");
    res(5, 'h900);
    expect_flag(0, 1'b0, "R8 run restarted");

    // Comparator 1: below 0x100, run of 2 on channel 7
    put(1'b0, 0, 0, 2'b10, mkcfg(1, 0, 2, 7, 'h100), 2'b00);
    res(7, 'h0FF);
    res(7, 'h100);
    res(7, 'h050);
    expect_flag(1, 1'b0, "R5 failing result breaks run");
    res(7, 'h000);
    expect_flag(1, 1'b1, "R3 R5 below condition");
    expect_flag(0, 1'b0, "R11 other comparator untouched");

    // Configuration write clears the run
    put(1'b0, 0, 0, 2'b01, mkcfg(1, 1, 2, 3, 0), 2'b00);
    res(3, 'h10);
    put(1'b0, 0, 0, 2'b01, mkcfg(1, 1, 2, 3, 0), 2'b00);
    res(3, 'h10);
    expect_flag(0, 1'b0, "R9 run cleared by write");
    res(3, 'h10);
    expect_flag(0, 1'b1, "R9 full run after write");
    put(1'b0, 0, 0, 2'b00, '0, 2'b01);

    // Result in the write cycle is ignored
    put(1'b1, 3, 5, 2'b01, mkcfg(1, 1, 1, 3, 0), 2'b00);
    expect_flag(0, 1'b0, "R9 result with write ignored");
    res(3, 5);
    expect_flag(0, 1'b1, "R4 run of one");

    // Set against clear in one cycle
    put(1'b1, 3, 5, 2'b00, '0, 2'b01);
    expect_flag(0, 1'b1, "R7 set wins over clear");
    put(1'b1, 4, 5, 2'b00, '0, 2'b01);
    expect_flag(0, 1'b0, "R7 clear with unrelated result");

    // Longest run: 16
    put(1'b0, 0, 0, 2'b01, mkcfg(1, 1, 16, 0, 0), 2'b00);
    for (int i = 0; i < 15; i++) res(0, i);
    expect_flag(0, 1'b0, "R4 fifteen of sixteen");
    res(0, 99);
    expect_flag(0, 1'b1, "R4 sixteen reached");

    // Disable keeps flag; disabled comparator does nothing
    put(1'b0, 0, 0, 2'b01, '0, 2'b00);
    expect_flag(0, 1'b1, "R9 disabling write keeps flag");
    put(1'b0, 0, 0, 2'b00, '0, 2'b01);
    put(1'b0, 0, 0, 2'b01, mkcfg(0, 1, 1, 0, 0), 2'b00);
    res(0, 7); res(0, 7); res(0, 7);
    expect_flag(0, 1'b0, "R10 disabled");

    // Threshold field at its top value
    put(1'b0, 0, 0, 2'b10, mkcfg(1, 1, 1, 0, 'hFFF), 2'b10);
    expect_flag(1, 1'b0, "R7 clear comparator 1");
    res(0, 'hFFE);
    expect_flag(1, 1'b0, "R2 R3 below top threshold");
    res(0, 'hFFF);
    expect_flag(1, 1'b1, "R2 top threshold reached");
    idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule